// File: doc/BRIEF.md
# Dual-Direction Serial Frame Monitor

This block listens, without driving anything, to two asynchronous serial lines: one carrying the receive direction and one carrying the transmit direction. Each line has its own decoder. A decoder waits for the idle-high line to fall and takes that cycle as the time origin of a frame. It then samples every bit at its centre and builds a data word of 5 to 9 bits. When the frame format calls for it, it checks a parity bit, and it always checks a single stop bit. Every stage produces a one-cycle event pulse together with the bit value it sampled, or the finished data word.

Frame timing and format are run-time inputs shared by both directions: an integer clocks-per-bit value, the data length, the parity mode and the bit order. These inputs should only change while both lines are idle. A start bit found high at its centre is flagged, but the decoder still collects the rest of that frame. The events feed logging or protocol-checking logic elsewhere on the chip.

Top module: `uart_mon`

## Requirements
- R1: After reset every event output is 0 and both word outputs are 0. With no falling edge on a line, that channel raises no event.
- R2: On each channel, a high-to-low transition of the line starts a frame. Inputs pass through a two-stage synchronizer. Bit index n is sampled once the cycles elapsed since the synchronized edge reach floor(cfg_cpb/2) + n*cfg_cpb. The start event (index 0) is visible 3 + floor(cfg_cpb/2) rising edges after the line falls. cfg_cpb must be at least 4.
- R3: With cfg_msb_first = 0 the first data bit on the line is the word's bit 0. Each new bit enters at position N-1 and the word shifts right.
- R4: With cfg_msb_first = 1 the first data bit on the line is the word's bit N-1. Each new bit enters at bit 0 and the word shifts left.
- R5: The data length N comes from cfg_len. Values below 5 act as 5 and values above 9 act as 9. Word bits at positions N and above read 0.
- R6: cfg_parity = 1 selects odd parity and 2 selects even parity. The ones in the N data bits and the parity bit are counted together. A count that matches the mode gives ev_par_ok, and a count that does not gives ev_par_err.
- R7: cfg_parity = 3 requires the parity bit to be 0 and cfg_parity = 4 requires it to be 1. A mismatch gives ev_par_err, and a match gives ev_par_ok.
- R8: cfg_parity = 0, or any value from 5 to 7, means no parity bit. No parity event is raised and the stop bit is sampled at index N+1. With parity enabled the stop bit is sampled at index N+2.
- R9: A start bit sampled as 1 raises ev_bad_start together with ev_start, with ev_bit = 1. The data, parity and stop bits of that frame are still decoded.
- R10: Every stop sample raises ev_stop with ev_bit carrying the sampled value. A 0 also raises ev_bad_stop. Either way the channel goes back to waiting for a falling edge.
- R11: Event bit 0 belongs to the receive line and bit 1 to the transmit line. The two channels share no state, so activity on one line causes no event on the other.
- R12: Each event is a single-cycle pulse. Per channel, at most one of start, data, parity-ok, parity-error and stop fires in a cycle, and a frame gives exactly one data event. rx_word and tx_word change only in the cycle their data event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Receive-direction serial line (idle high) |
| tx_line | input | 1 | Transmit-direction serial line (idle high) |
| cfg_cpb | input | CPB_W | Clock cycles per bit, at least 4 |
| cfg_len | input | 4 | Data bits per frame, 5 to 9 (clamped) |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 always-0, 4 always-1, 5-7 none |
| cfg_msb_first | input | 1 | 1 = most significant data bit first |
| ev_start | output | 2 | Start bit sampled, per channel |
| ev_bad_start | output | 2 | Start bit sampled high |
| ev_data | output | 2 | Data word complete |
| ev_par_ok | output | 2 | Parity bit matched the mode |
| ev_par_err | output | 2 | Parity bit did not match the mode |
| ev_stop | output | 2 | Stop bit sampled |
| ev_bad_stop | output | 2 | Stop bit sampled low |
| ev_bit | output | 2 | Sampled bit for start, parity and stop events |
| rx_word | output | 9 | Last data word of the receive channel |
| tx_word | output | 9 | Last data word of the transmit channel |

## Verification
The hardest case to reach from the ports is a frame whose start edge is real but whose start bit reads high at its centre. The line has to drop for no more than half a bit and then recover before the centre sample, and decoding must still go on. The bench builds such frames with a chosen glitch width and checks that the data, parity and stop that follow still decode. It also overlaps frames on both lines with random offsets to expose any shared state, and it sends a low stop bit with parity off to show the stop sample lands at index N+1 and not one bit later.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

    localparam int WORD_W  = 9;
    localparam int LEN_W   = 4;
    localparam int MIN_LEN = 5;
    localparam int MAX_LEN = 9;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_EVEN = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } chan_state_e;

    typedef struct packed {
        logic start;
        logic bad_start;
        logic data;
        logic par_ok;
        logic par_err;
        logic stop;
        logic bad_stop;
        logic bit_v;
    } evt_t;

endpackage

// File: rtl/uart_mon_sync.sv
module uart_mon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign line_s    = chain_q[STAGES-1];
    assign line_fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_mon_bitclk.sv
module uart_mon_bitclk #(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic [CPB_W-1:0] cpb,
    output logic             hit
);
    localparam int ELAP_W = CPB_W + 4;

    logic [ELAP_W-1:0] elap_q;
    logic [ELAP_W-1:0] tgt_q;

    assign hit = run && (elap_q == tgt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elap_q <= '0;
            tgt_q  <= '0;
        end else if (arm) begin
            elap_q <= ELAP_W'(1);
            tgt_q  <= ELAP_W'(cpb >> 1);
        end else if (run) begin
            elap_q <= elap_q + ELAP_W'(1);
            if (hit) begin
                tgt_q <= tgt_q + ELAP_W'(cpb);
            end
        end
    end
endmodule

// File: rtl/uart_mon_chan.sv
module uart_mon_chan
    import uart_mon_pkg::*;
#(
    parameter int CPB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    input  logic              line_fall,
    input  logic [CPB_W-1:0]  cpb,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        parity,
    input  logic              msb_first,
    output evt_t              evt,
    output logic [WORD_W-1:0] word_out
);
    chan_state_e       state_q, state_d;
    logic [LEN_W-1:0]  didx_q;
    logic [LEN_W-1:0]  eff_len;
    logic [WORD_W-1:0] shift_q, shift_nx;
    logic              hit, arm, run;
    logic              last_data, par_en, par_good, ones_odd;

    assign arm = (state_q == ST_IDLE) && line_fall;
    assign run = (state_q != ST_IDLE);

    uart_mon_bitclk #(.CPB_W(CPB_W)) u_bitclk (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .run   (run),
        .cpb   (cpb),
        .hit   (hit)
    );

    always_comb begin
        if (len < LEN_W'(MIN_LEN))      eff_len = LEN_W'(MIN_LEN);
        else if (len > LEN_W'(MAX_LEN)) eff_len = LEN_W'(MAX_LEN);
        else                            eff_len = len;
    end

    assign last_data = (didx_q == eff_len - LEN_W'(1));

    always_comb begin
        if (msb_first) shift_nx = {shift_q[WORD_W-2:0], line_s};
        else           shift_nx = (shift_q >> 1) |
                                  ({{(WORD_W-1){1'b0}}, line_s} << (eff_len - LEN_W'(1)));
    end

    assign par_en   = (parity == PAR_ODD) || (parity == PAR_EVEN) ||
                      (parity == PAR_ZERO) || (parity == PAR_ONE);
    assign ones_odd = (^shift_q) ^ line_s;

    always_comb begin
        case (parity)
            PAR_ODD:  par_good = ones_odd;
            PAR_EVEN: par_good = ~ones_odd;
            PAR_ZERO: par_good = ~line_s;
            PAR_ONE:  par_good = line_s;
            default:  par_good = 1'b1;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (line_fall) state_d = ST_START;
            ST_START:  if (hit) state_d = ST_DATA;
            ST_DATA:   if (hit && last_data) state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (hit) state_d = ST_STOP;
            ST_STOP:   if (hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register with the data path it sequences
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            didx_q  <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (hit && state_q == ST_START) begin
                didx_q  <= '0;
                shift_q <= '0;
            end else if (hit && state_q == ST_DATA) begin
                didx_q  <= didx_q + LEN_W'(1);
                shift_q <= shift_nx;
            end
        end
    end

    // event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt      <= '0;
            word_out <= '0;
        end else begin
            evt <= '0;
            if (hit) begin
                case (state_q)
                    ST_START: begin
                        evt.start     <= 1'b1;
                        evt.bad_start <= line_s;
                        evt.bit_v     <= line_s;
                    end
                    ST_DATA: begin
                        if (last_data) begin
                            evt.data <= 1'b1;
                            word_out <= shift_nx;
                        end
                    end
                    ST_PARITY: begin
                        evt.par_ok  <= par_good;
                        evt.par_err <= ~par_good;
                        evt.bit_v   <= line_s;
                    end
                    ST_STOP: begin
                        evt.stop     <= 1'b1;
                        evt.bad_stop <= ~line_s;
                        evt.bit_v    <= line_s;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_mon.sv
module uart_mon
    import uart_mon_pkg::*;
#(
    parameter int CPB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tx_line,
    input  logic [CPB_W-1:0]  cfg_cpb,
    input  logic [3:0]        cfg_len,
    input  logic [2:0]        cfg_parity,
    input  logic              cfg_msb_first,
    output logic [1:0]        ev_start,
    output logic [1:0]        ev_bad_start,
    output logic [1:0]        ev_data,
    output logic [1:0]        ev_par_ok,
    output logic [1:0]        ev_par_err,
    output logic [1:0]        ev_stop,
    output logic [1:0]        ev_bad_stop,
    output logic [1:0]        ev_bit,
    output logic [8:0]        rx_word,
    output logic [8:0]        tx_word
);
    localparam int NCH = 2;

    logic [NCH-1:0]    lines;
    evt_t              evt  [NCH];
    logic [WORD_W-1:0] word [NCH];

    assign lines = {tx_line, rx_line};

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic line_s, line_fall;

        uart_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_in   (lines[gi]),
            .line_s    (line_s),
            .line_fall (line_fall)
        );

        uart_mon_chan #(.CPB_W(CPB_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_s    (line_s),
            .line_fall (line_fall),
            .cpb       (cfg_cpb),
            .len       (cfg_len),
            .parity    (cfg_parity),
            .msb_first (cfg_msb_first),
            .evt       (evt[gi]),
            .word_out  (word[gi])
        );

        assign ev_start[gi]     = evt[gi].start;
        assign ev_bad_start[gi] = evt[gi].bad_start;
        assign ev_data[gi]      = evt[gi].data;
        assign ev_par_ok[gi]    = evt[gi].par_ok;
        assign ev_par_err[gi]   = evt[gi].par_err;
        assign ev_stop[gi]      = evt[gi].stop;
        assign ev_bad_stop[gi]  = evt[gi].bad_stop;
        assign ev_bit[gi]       = evt[gi].bit_v;
    end

    assign rx_word = word[0];
    assign tx_word = word[1];
endmodule

// File: rtl/uart_mon_chk.sv
module uart_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_parity,
    input logic [1:0] ev_start,
    input logic [1:0] ev_bad_start,
    input logic [1:0] ev_data,
    input logic [1:0] ev_par_ok,
    input logic [1:0] ev_par_err,
    input logic [1:0] ev_stop,
    input logic [1:0] ev_bad_stop,
    input logic [1:0] ev_bit,
    input logic [8:0] rx_word,
    input logic [8:0] tx_word
);
    logic [8:0] wd [2];
    assign wd[0] = rx_word;
    assign wd[1] = tx_word;

    for (genvar c = 0; c < 2; c++) begin : g_c
        AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({ev_start[c], ev_data[c], ev_par_ok[c], ev_par_err[c], ev_stop[c]})); // R12
        AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ev_data[c] |=> !ev_data[c]); // R12
        AST_WORD_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(wd[c]) |-> ev_data[c]); // R12
        AST_BAD_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            ev_bad_start[c] |-> (ev_start[c] && ev_bit[c])); // R9
        AST_BAD_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            ev_bad_stop[c] |-> (ev_stop[c] && !ev_bit[c])); // R10
        AST_GOOD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_stop[c] && ev_bit[c]) |-> !ev_bad_stop[c]); // R10
        AST_NO_PARITY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_parity == 3'd0 || cfg_parity > 3'd4) |-> !(ev_par_ok[c] || ev_par_err[c])); // R8
    end
endmodule

bind uart_mon uart_mon_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_parity   (cfg_parity),
    .ev_start     (ev_start),
    .ev_bad_start (ev_bad_start),
    .ev_data      (ev_data),
    .ev_par_ok    (ev_par_ok),
    .ev_par_err   (ev_par_err),
    .ev_stop      (ev_stop),
    .ev_bad_stop  (ev_bad_stop),
    .ev_bit       (ev_bit),
    .rx_word      (rx_word),
    .tx_word      (tx_word)
);

// File: tb/uart_mon_bench.sv
module uart_mon_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        tx_line = 1'b1;
    logic [15:0] cfg_cpb = 16'd8;
    logic [3:0]  cfg_len = 4'd8;
    logic [2:0]  cfg_parity = 3'd0;
    logic        cfg_msb_first = 1'b0;
    logic [1:0]  ev_start, ev_bad_start, ev_data, ev_par_ok, ev_par_err;
    logic [1:0]  ev_stop, ev_bad_stop, ev_bit;
    logic [8:0]  rx_word, tx_word;

    int n_chk = 0;
    int n_err = 0;

    int c_start[2], c_bstart[2], c_data[2], c_pok[2], c_perr[2], c_stop[2], c_bstop[2];
    int s_startbit[2], s_stopbit[2];
    int s_word[2];

    int e_act[2], e_data[2], e_glitch[2], e_flip[2], e_stopv[2];

    always #2 clk = ~clk;

    uart_mon #(.CPB_W(16)) u_uart_mon (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tx_line(tx_line),
        .cfg_cpb(cfg_cpb), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
        .cfg_msb_first(cfg_msb_first),
        .ev_start(ev_start), .ev_bad_start(ev_bad_start), .ev_data(ev_data),
        .ev_par_ok(ev_par_ok), .ev_par_err(ev_par_err), .ev_stop(ev_stop),
        .ev_bad_stop(ev_bad_stop), .ev_bit(ev_bit),
        .rx_word(rx_word), .tx_word(tx_word)
    );

    function automatic int eff_len(int l);
        if (l < 5) return 5;
        if (l > 9) return 9;
        return l;
    endfunction

    function automatic int par_on(int m);
        return (m >= 1 && m <= 4) ? 1 : 0;
    endfunction

    function automatic int par_bit(int m, int d, int l);
        int ones = 0;
        for (int i = 0; i < l; i++) ones += (d >> i) & 1;
        case (m)
            1: return (ones % 2 == 1) ? 0 : 1;
            2: return ones % 2;
            3: return 0;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (ev_start[c])     begin c_start[c]++; s_startbit[c] = ev_bit[c]; end
                if (ev_bad_start[c]) c_bstart[c]++;
                if (ev_data[c])      begin c_data[c]++; s_word[c] = (c == 0) ? rx_word : tx_word; end
                if (ev_par_ok[c])    c_pok[c]++;
                if (ev_par_err[c])   c_perr[c]++;
                if (ev_stop[c])      begin c_stop[c]++; s_stopbit[c] = ev_bit[c]; end
                if (ev_bad_stop[c])  c_bstop[c]++;
            end
        end
    end

    task automatic clear_counts();
        for (int c = 0; c < 2; c++) begin
            c_start[c] = 0; c_bstart[c] = 0; c_data[c] = 0; c_pok[c] = 0;
            c_perr[c] = 0; c_stop[c] = 0; c_bstop[c] = 0;
            s_startbit[c] = -1; s_stopbit[c] = -1; s_word[c] = -1;
            e_act[c] = 0;
        end
    endtask

    task automatic put_line(int ch, logic v);
        if (ch == 0) rx_line = v; else tx_line = v;
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(int ch, int d, int glitch, int flip, int stopv);
        int cpb = int'(cfg_cpb);
        int l   = eff_len(int'(cfg_len));
        if (glitch > 0) begin
            put_line(ch, 1'b0); hold(glitch);
            put_line(ch, 1'b1); hold(cpb - glitch);
        end else begin
            put_line(ch, 1'b0); hold(cpb);
        end
        for (int i = 0; i < l; i++) begin
            int b = cfg_msb_first ? (d >> (l - 1 - i)) & 1 : (d >> i) & 1;
            put_line(ch, logic'(b)); hold(cpb);
        end
        if (par_on(int'(cfg_parity)) != 0) begin
            put_line(ch, logic'(par_bit(int'(cfg_parity), d, l) ^ flip)); hold(cpb);
        end
        put_line(ch, logic'(stopv)); hold(cpb);
        put_line(ch, 1'b1); hold(2 * cpb);
    endtask

    task automatic verify_chan(int c);
        int m    = int'(cfg_parity);
        int l    = eff_len(int'(cfg_len));
        int mask = (1 << l) - 1;
        int port = (c == 0) ? int'(rx_word) : int'(tx_word);
        string wtag = cfg_msb_first ? "R4" : "R3";
        string ptag = (m == 1 || m == 2) ? "R6" : ((m == 3 || m == 4) ? "R7" : "R8");
        if (e_act[c] == 0) begin
            chk("R11", c_start[c] + c_data[c] + c_stop[c] + c_pok[c] + c_perr[c], 0,
                $sformatf("events on quiet channel %0d", c));
            return;
        end
        chk("R2", c_start[c], 1, $sformatf("start count ch%0d", c));
        chk("R9", s_startbit[c], (e_glitch[c] > 0) ? 1 : 0, $sformatf("start bit ch%0d", c));
        chk("R9", c_bstart[c], (e_glitch[c] > 0) ? 1 : 0, $sformatf("bad start ch%0d", c));
        chk("R12", c_data[c], 1, $sformatf("data count ch%0d", c));
        chk(wtag, s_word[c], e_data[c] & mask, $sformatf("data word ch%0d len%0d", c, l));
        chk(wtag, port, e_data[c] & mask, $sformatf("word port ch%0d", c));
        chk(ptag, c_pok[c], (par_on(m) != 0 && e_flip[c] == 0) ? 1 : 0, $sformatf("parity ok ch%0d mode%0d", c, m));
        chk(ptag, c_perr[c], (par_on(m) != 0 && e_flip[c] != 0) ? 1 : 0, $sformatf("parity err ch%0d mode%0d", c, m));
        chk("R10", c_stop[c], 1, $sformatf("stop count ch%0d", c));
        chk("R10", s_stopbit[c], e_stopv[c], $sformatf("stop bit ch%0d", c));
        chk("R10", c_bstop[c], (e_stopv[c] == 0) ? 1 : 0, $sformatf("bad stop ch%0d", c));
    endtask

    task automatic run_pair(int use0, int use1, int d0, int d1, int g0, int g1,
                            int f0, int f1, int s0, int s1, int off);
        @(posedge clk);
        clear_counts();
        e_act[0] = use0; e_data[0] = d0; e_glitch[0] = g0; e_flip[0] = f0; e_stopv[0] = s0;
        e_act[1] = use1; e_data[1] = d1; e_glitch[1] = g1; e_flip[1] = f1; e_stopv[1] = s1;
        @(negedge clk);
        fork
            begin if (use0 != 0) send_frame(0, d0, g0, f0, s0); end
            begin if (use1 != 0) begin hold(off); send_frame(1, d1, g1, f1, s1); end end
        join
        hold(4);
        @(posedge clk);
        verify_chan(0);
        verify_chan(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int lat;
        void'($urandom(32'd7331));
        clear_counts();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: quiet after reset
        chk("R1", int'({ev_start, ev_data, ev_stop, ev_par_ok, ev_par_err, ev_bad_start, ev_bad_stop}), 0, "events after reset");
        chk("R1", int'(rx_word) + int'(tx_word), 0, "words after reset");
        chk("R1", c_start[0] + c_start[1], 0, "no frames without edge");

        // R2: start latency, cpb 8, LSB first, no parity
        cfg_cpb = 16'd8; cfg_len = 4'd8; cfg_parity = 3'd0; cfg_msb_first = 1'b0;
        @(posedge clk);
        clear_counts();
        e_act[0] = 1; e_data[0] = 8'hA5; e_glitch[0] = 0; e_flip[0] = 0; e_stopv[0] = 1;
        @(negedge clk);
        lat = 0;
        fork
            send_frame(0, 8'hA5, 0, 0, 1);
            begin
                for (int k = 0; k < 100; k++) begin
                    @(negedge clk);
                    lat++;
                    if (ev_start[0]) break;
                end
            end
        join
        hold(4);
        @(posedge clk);
        chk("R2", lat, 7, "start event latency in rising edges");
        verify_chan(0);
        verify_chan(1);

        // R5: length clamps
        cfg_len = 4'd3; cfg_msb_first = 1'b1;
        run_pair(1, 0, 9'h1D, 0, 0, 0, 0, 0, 1, 1, 0);
        chk("R5", int'(rx_word), 9'h1D, "length 3 acts as 5");
        cfg_len = 4'd12; cfg_msb_first = 1'b0;
        run_pair(0, 1, 0, 9'h1C3, 0, 0, 0, 0, 1, 1, 0);
        chk("R5", int'(tx_word), 9'h1C3, "length 12 acts as 9");

        // R7: stick parity with good and bad parity bits
        cfg_len = 4'd7; cfg_parity = 3'd3;
        run_pair(1, 1, 7'h55, 7'h2A, 0, 0, 0, 1, 1, 1, 5);
        cfg_parity = 3'd4;
        run_pair(1, 1, 7'h0F, 7'h70, 0, 0, 1, 0, 1, 1, 3);

        // R6: odd and even
        cfg_len = 4'd8; cfg_parity = 3'd1;
        run_pair(1, 1, 8'h00, 8'hFF, 0, 0, 0, 1, 1, 1, 2);
        cfg_parity = 3'd2;
        run_pair(1, 1, 8'h01, 8'h80, 0, 0, 1, 0, 1, 1, 9);

        // R8: no parity, low stop at index N+1; mode 6 also means none
        cfg_parity = 3'd0;
        run_pair(1, 0, 8'h3C, 0, 0, 0, 0, 0, 0, 1, 0);
        cfg_parity = 3'd6;
        run_pair(0, 1, 0, 8'hC3, 0, 0, 0, 0, 0, 0, 0);

        // R9: start glitch, frame still decoded
        cfg_parity = 3'd2; cfg_cpb = 16'd10;
        run_pair(1, 1, 8'h96, 8'h69, 1, 5, 0, 0, 1, 1, 4);

        // R11: only receive line active
        run_pair(1, 0, 8'h5A, 0, 0, 0, 0, 0, 1, 1, 0);

        // random mix
        for (int it = 0; it < 30; it++) begin
            int cpb = 4 + int'($urandom % 13);
            int l, half;
            cfg_cpb = 16'(cpb);
            cfg_len = 4'(5 + $urandom % 5);
            cfg_parity = 3'($urandom % 5);
            cfg_msb_first = 1'($urandom % 2);
            l = eff_len(int'(cfg_len));
            half = cpb / 2;
            run_pair(1, 1,
                     int'($urandom) & ((1 << l) - 1), int'($urandom) & ((1 << l) - 1),
                     ($urandom % 6 == 0) ? 1 + int'($urandom % half) : 0,
                     ($urandom % 6 == 0) ? 1 + int'($urandom % half) : 0,
                     ($urandom % 4 == 0) ? 1 : 0, ($urandom % 4 == 0) ? 1 : 0,
                     ($urandom % 5 == 0) ? 0 : 1, ($urandom % 5 == 0) ? 0 : 1,
                     int'($urandom % (3 * cpb)));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule